// File: doc/BRIEF.md
# DDR3 Command and Address Decoder

This block watches the command and address pins of a DDR3 device on each rising clock edge and turns every sampled cycle into one decoded command record. The record gives the command kind, the target bank, the row or column, the auto-precharge and precharge-all flags, the burst length of the access, and the mode-register index and opcode. The meaning of each field depends on the command. On a read or write, address bit 10 is the auto-precharge flag. On a precharge, bit 10 selects all banks. On a read or write, bit 12 picks the burst length when on-the-fly burst selection is enabled. On a mode load, the bank pins pick the register.

The block also keeps a bitmap of the eight banks that are currently open. It raises a one-cycle error when an access goes to a closed bank, or when an activate goes to a bank that is already open. It keeps a shadow copy of the burst-mode field of mode register 0, so the burst length it reports follows whatever mode the controller has loaded. A monitor or protocol checker uses it to follow DRAM traffic cycle by cycle.

Top module: `ddr3_cmd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, `cmd_o` is 0 (NOP), every other output is 0, the open-bank bitmap is empty, and the burst-mode shadow returns to on-the-fly (code 01).
- R2: When `cke_i` is low at an edge, the record after that edge is NOP with zero fields. The open-bank bitmap, the burst-mode shadow and `err_o` are not changed by the pins.
- R3: When `cke_i` is high and `cs_n_i` is high, the record after the edge is deselect (code 7), whatever the other pins carry, and all data fields are 0.
- R4: With chip select low, the pins {cs_n, ras_n, cas_n, we_n} decode as follows: 0011 gives activate (1), 0101 read (2), 0100 write (3), 0010 precharge (4), 0000 mode load (5), 0001 refresh (6) and 0111 NOP (0). The unlisted code 0110 gives NOP. The result appears on the outputs one clock edge after the pins are sampled.
- R5: An activate reports `bank_o` = `ba_i` and `row_o` = the full ROW_W-bit `addr_i`, and it sets that bank's bit in `open_banks_o` in the same record.
- R6: A read or write reports `bank_o`, `col_o` = `addr_i[9:0]` and `auto_pre_o` = `addr_i[10]`. With auto-precharge set, it clears that bank's bit in the same record.
- R7: A precharge reports `pre_all_o` = `addr_i[10]` and `bank_o` = `ba_i`. With bit 10 low it clears only the bit of bank `ba_i`; with bit 10 high it clears all eight bits.
- R8: On a read or write, `bl8_o` is 1 for a burst of 8 and 0 for a chop of 4. The shadowed burst mode selects the source: 00 fixes 8, 10 fixes 4, and 01 or 11 take `addr_i[12]` (1 = 8).
- R9: A mode load reports `mr_sel_o` = `ba_i[1:0]` and `mr_op_o` = `addr_i`. A load with `ba_i[1:0]` = 0 copies `addr_i[1:0]` into the burst-mode shadow, which takes effect from the next command. Loads to other registers leave the shadow unchanged.
- R10: `err_o` is 1 in exactly the record of a read or write to a bank whose bit is clear, or of an activate to a bank whose bit is set. It is 0 otherwise.
- R11: A field that does not belong to the reported command is 0. Examples are the row outside activate, the column, auto-precharge and burst length outside read and write, and the mode fields outside mode load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cke_i | input | 1 | Clock enable, high to sample the command |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe command pin, active low |
| cas_n_i | input | 1 | Column strobe command pin, active low |
| we_n_i | input | 1 | Write-enable command pin, active low |
| ba_i | input | 3 | Bank address |
| addr_i | input | ROW_W | Row/column/opcode address bus |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 3 | Target bank |
| row_o | output | ROW_W | Row of an activate |
| col_o | output | 10 | Column of a read or write |
| auto_pre_o | output | 1 | Auto-precharge requested |
| pre_all_o | output | 1 | Precharge closes all banks |
| bl8_o | output | 1 | 1 = burst of 8, 0 = chop of 4 |
| mr_sel_o | output | 2 | Mode register being loaded |
| mr_op_o | output | ROW_W | Mode register opcode |
| open_banks_o | output | 8 | Bitmap of open banks after this command |
| err_o | output | 1 | Access to closed bank or reopen of open bank |

## Verification
On every cycle the bound checker checks the following. A stalled clock enable yields NOP and leaves the bitmap alone. Deselect overrides any other pin code. An error appears only alongside an activate, read or write. Activates, auto-precharges and precharge-all leave the bitmap in a consistent state. Unused fields stay at zero. Only the bench scenarios show the rest, because a per-cycle property cannot express it. This covers the exact pin-to-command table and the column and row bit placement. It also covers the order-dependent effects: a mode load changes the burst length of later reads, and a second activate or an access after auto-precharge raises the error.

// File: rtl/ddr3_cmd_pkg.sv
package ddr3_cmd_pkg;

    localparam int NUM_BANKS = 8;
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int COL_W     = 10;
    localparam int AP_BIT    = 10;
    localparam int BL_BIT    = 12;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_ACT   = 4'd1,
        CMD_RD    = 4'd2,
        CMD_WR    = 4'd3,
        CMD_PRE   = 4'd4,
        CMD_MRS   = 4'd5,
        CMD_REF   = 4'd6,
        CMD_DESEL = 4'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BURST_FIX8 = 2'b00,
        BURST_OTF  = 2'b01,
        BURST_FIX4 = 2'b10,
        BURST_RSVD = 2'b11
    } burst_mode_e;

    typedef struct packed {
        cmd_e            cmd;
        logic [BA_W-1:0] bank;
        logic            ap;
        logic            pa;
        logic            bl8;
        logic [1:0]      mr_sel;
    } cmd_info_t;

    function automatic cmd_e pins_to_cmd(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b000:  c = CMD_MRS;
                3'b001:  c = CMD_REF;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic pick_bl8(input burst_mode_e mode, input logic a12);
        logic r;
        case (mode)
            BURST_FIX8: r = 1'b1;
            BURST_FIX4: r = 1'b0;
            default:    r = a12;
        endcase
        return r;
    endfunction

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/ddr3_cmd_field_decode.sv
module ddr3_cmd_field_decode
    import ddr3_cmd_pkg::*;
#(
    parameter int ROW_W = 15
) (
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BA_W-1:0]  ba,
    input  logic [ROW_W-1:0] addr,
    input  burst_mode_e      burst_mode,
    output cmd_info_t        info,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] op
);

    cmd_e cmd_raw;

    always_comb begin
        cmd_raw = cke ? pins_to_cmd(cs_n, ras_n, cas_n, we_n) : CMD_NOP;

        info        = '0;
        info.cmd    = cmd_raw;
        row         = '0;
        col         = '0;
        op          = '0;

        case (cmd_raw)
            CMD_ACT: begin
                info.bank = ba;
                row       = addr;
            end
            CMD_RD, CMD_WR: begin
                info.bank = ba;
                info.ap   = addr[AP_BIT];
                info.bl8  = pick_bl8(burst_mode, addr[BL_BIT]);
                col       = addr[COL_W-1:0];
            end
            CMD_PRE: begin
                info.bank = ba;
                info.pa   = addr[AP_BIT];
            end
            CMD_MRS: begin
                info.mr_sel = ba[1:0];
                op          = addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr3_mode_shadow.sv
module ddr3_mode_shadow
    import ddr3_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cmd_info_t   info,
    input  logic [1:0]  op_burst,
    output burst_mode_e burst_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_mode <= BURST_OTF;
        end else if (info.cmd == CMD_MRS && info.mr_sel == 2'd0) begin
            burst_mode <= burst_mode_e'(op_burst);
        end
    end

endmodule

// File: rtl/ddr3_bank_tracker.sv
module ddr3_bank_tracker
    import ddr3_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_info_t            info,
    output logic [NUM_BANKS-1:0] open_map,
    output logic                 err
);

    logic [NUM_BANKS-1:0] map_next;
    logic                 err_next;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (info.bank == BA_W'(b));
        always_comb begin
            map_next[b] = open_map[b];
            case (info.cmd)
                CMD_ACT: if (hit) map_next[b] = 1'b1;
                CMD_PRE: if (hit || info.pa) map_next[b] = 1'b0;
                CMD_RD, CMD_WR: if (hit && info.ap) map_next[b] = 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        err_next = 1'b0;
        if (is_access(info.cmd) && !open_map[info.bank]) err_next = 1'b1;
        if (info.cmd == CMD_ACT && open_map[info.bank])  err_next = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_map <= '0;
            err      <= 1'b0;
        end else begin
            open_map <= map_next;
            err      <= err_next;
        end
    end

endmodule

// File: rtl/ddr3_cmd_decoder.sv
module ddr3_cmd_decoder
    import ddr3_cmd_pkg::*;
#(
    parameter int ROW_W = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke_i,
    input  logic                 cs_n_i,
    input  logic                 ras_n_i,
    input  logic                 cas_n_i,
    input  logic                 we_n_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic [ROW_W-1:0]     addr_i,
    output logic [3:0]           cmd_o,
    output logic [BA_W-1:0]      bank_o,
    output logic [ROW_W-1:0]     row_o,
    output logic [COL_W-1:0]     col_o,
    output logic                 auto_pre_o,
    output logic                 pre_all_o,
    output logic                 bl8_o,
    output logic [1:0]           mr_sel_o,
    output logic [ROW_W-1:0]     mr_op_o,
    output logic [NUM_BANKS-1:0] open_banks_o,
    output logic                 err_o
);

    localparam int MIN_ROW_W = BL_BIT + 1;

    initial begin
        if (ROW_W < MIN_ROW_W) $error("ROW_W too small for burst select bit");
    end

    cmd_info_t        dec_info;
    logic [ROW_W-1:0] dec_row;
    logic [COL_W-1:0] dec_col;
    logic [ROW_W-1:0] dec_op;
    burst_mode_e      burst_mode;
    cmd_info_t        info_q;

    ddr3_cmd_field_decode #(.ROW_W(ROW_W)) u_decode (
        .cke        (cke_i),
        .cs_n       (cs_n_i),
        .ras_n      (ras_n_i),
        .cas_n      (cas_n_i),
        .we_n       (we_n_i),
        .ba         (ba_i),
        .addr       (addr_i),
        .burst_mode (burst_mode),
        .info       (dec_info),
        .row        (dec_row),
        .col        (dec_col),
        .op         (dec_op)
    );

    ddr3_mode_shadow u_mode (
        .clk        (clk),
        .rst        (rst),
        .info       (dec_info),
        .op_burst   (dec_op[1:0]),
        .burst_mode (burst_mode)
    );

    ddr3_bank_tracker u_banks (
        .clk      (clk),
        .rst      (rst),
        .info     (dec_info),
        .open_map (open_banks_o),
        .err      (err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q  <= '0;
            row_o   <= '0;
            col_o   <= '0;
            mr_op_o <= '0;
        end else begin
            info_q  <= dec_info;
            row_o   <= dec_row;
            col_o   <= dec_col;
            mr_op_o <= dec_op;
        end
    end

    assign cmd_o      = info_q.cmd;
    assign bank_o     = info_q.bank;
    assign auto_pre_o = info_q.ap;
    assign pre_all_o  = info_q.pa;
    assign bl8_o      = info_q.bl8;
    assign mr_sel_o   = info_q.mr_sel;

endmodule

// File: rtl/ddr3_cmd_decoder_chk.sv
module ddr3_cmd_decoder_chk
    import ddr3_cmd_pkg::*;
#(
    parameter int ROW_W = 15
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cke_i,
    input logic                 cs_n_i,
    input logic [3:0]           cmd_o,
    input logic [BA_W-1:0]      bank_o,
    input logic [ROW_W-1:0]     row_o,
    input logic [COL_W-1:0]     col_o,
    input logic                 auto_pre_o,
    input logic                 pre_all_o,
    input logic [ROW_W-1:0]     mr_op_o,
    input logic [NUM_BANKS-1:0] open_banks_o,
    input logic                 err_o
);

    assert_stall_nop_R2: assert property (@(posedge clk) disable iff (rst)
        !cke_i |=> (cmd_o == 4'(CMD_NOP)) && $stable(open_banks_o) && !err_o);

    assert_deselect_R3: assert property (@(posedge clk) disable iff (rst)
        (cke_i && cs_n_i) |=> (cmd_o == 4'(CMD_DESEL)) && (row_o == '0) && (col_o == '0));

    assert_err_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (cmd_o == 4'(CMD_ACT) || cmd_o == 4'(CMD_RD) || cmd_o == 4'(CMD_WR)));

    assert_pre_all_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'(CMD_PRE) && pre_all_o) |-> (open_banks_o == '0));

    assert_act_open_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'(CMD_ACT)) |-> open_banks_o[bank_o]);

    assert_one_open_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(open_banks_o) <= $countones($past(open_banks_o)) + 1);

    assert_autopre_close_R6: assert property (@(posedge clk) disable iff (rst)
        ((cmd_o == 4'(CMD_RD) || cmd_o == 4'(CMD_WR)) && auto_pre_o) |-> !open_banks_o[bank_o]);

    assert_idle_fields_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 4'(CMD_NOP) || cmd_o == 4'(CMD_REF) || cmd_o == 4'(CMD_DESEL))
        |-> (bank_o == '0) && (row_o == '0) && (col_o == '0) && !auto_pre_o
            && !pre_all_o && (mr_op_o == '0));

endmodule

bind ddr3_cmd_decoder ddr3_cmd_decoder_chk #(.ROW_W(ROW_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cke_i        (cke_i),
    .cs_n_i       (cs_n_i),
    .cmd_o        (cmd_o),
    .bank_o       (bank_o),
    .row_o        (row_o),
    .col_o        (col_o),
    .auto_pre_o   (auto_pre_o),
    .pre_all_o    (pre_all_o),
    .mr_op_o      (mr_op_o),
    .open_banks_o (open_banks_o),
    .err_o        (err_o)
);

// File: tb/tb_ddr3_cmd_decoder.sv
`timescale 1ns/1ps
module tb_ddr3_cmd_decoder;

    localparam int ROW_W = 15;
    localparam int VW    = 4 + 3 + ROW_W + 10 + 1 + 1 + 1 + 2 + ROW_W + 8 + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cke_i = 1'b0, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic [2:0]       ba_i = '0;
    logic [ROW_W-1:0] addr_i = '0;
    logic [3:0]       cmd_o;
    logic [2:0]       bank_o;
    logic [ROW_W-1:0] row_o;
    logic [9:0]       col_o;
    logic             auto_pre_o, pre_all_o, bl8_o;
    logic [1:0]       mr_sel_o;
    logic [ROW_W-1:0] mr_op_o;
    logic [7:0]       open_banks_o;
    logic             err_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    logic [7:0] m_open = '0;
    logic [1:0] m_mode = 2'b01;

    always #2.5 clk = ~clk;

    ddr3_cmd_decoder #(.ROW_W(ROW_W)) dut (.*);

    function automatic logic [VW-1:0] actual_vec();
        return {cmd_o, bank_o, row_o, col_o, auto_pre_o, pre_all_o, bl8_o,
                mr_sel_o, mr_op_o, open_banks_o, err_o};
    endfunction

    function automatic logic [ROW_W-1:0] rw_addr(input logic [9:0] c, input logic ap, input logic a12);
        logic [ROW_W-1:0] a = '0;
        a[9:0] = c;
        a[10]  = ap;
        a[12]  = a12;
        return a;
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one pin cycle and pushes the expected record
    task automatic issue(input logic cke, input logic [3:0] pins, input logic [2:0] ba,
                         input logic [ROW_W-1:0] a, input string tag);
        logic [3:0] c = 4'd0;
        logic [2:0] e_bank = '0;
        logic [ROW_W-1:0] e_row = '0, e_op = '0;
        logic [9:0] e_col = '0;
        logic e_ap = 0, e_pa = 0, e_bl8 = 0, e_err = 0;
        logic [1:0] e_sel = '0;
        @(negedge clk);
        cke_i = cke; {cs_n_i, ras_n_i, cas_n_i, we_n_i} = pins; ba_i = ba; addr_i = a;
        if (!cke) c = 4'd0;
        else if (pins[3]) c = 4'd7;
        else case (pins[2:0])
            3'b011: c = 4'd1;
            3'b101: c = 4'd2;
            3'b100: c = 4'd3;
            3'b010: c = 4'd4;
            3'b000: c = 4'd5;
            3'b001: c = 4'd6;
            default: c = 4'd0;
        endcase
        case (c)
            4'd1: begin
                e_bank = ba; e_row = a;
                e_err = m_open[ba];
                m_open[ba] = 1'b1;
            end
            4'd2, 4'd3: begin
                e_bank = ba; e_col = a[9:0]; e_ap = a[10];
                e_bl8 = (m_mode == 2'b00) ? 1'b1 : (m_mode == 2'b10) ? 1'b0 : a[12];
                e_err = !m_open[ba];
                if (a[10]) m_open[ba] = 1'b0;
            end
            4'd4: begin
                e_bank = ba; e_pa = a[10];
                if (a[10]) m_open = '0; else m_open[ba] = 1'b0;
            end
            4'd5: begin
                e_sel = ba[1:0]; e_op = a;
                if (ba[1:0] == 2'd0) m_mode = a[1:0];
            end
            default: ;
        endcase
        exp_q.push_back({c, e_bank, e_row, e_col, e_ap, e_pa, e_bl8, e_sel, e_op, m_open, e_err});
        tag_q.push_back(tag);
    endtask

    // monitor: compares each record after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [VW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, actual_vec(), e);
            end
        end
    end

    localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                           P_PRE = 4'b0010, P_MRS = 4'b0000, P_REF = 4'b0001,
                           P_NOP = 4'b0111, P_X = 4'b0110, P_DES = 4'b1000;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", actual_vec(), '0);
        @(negedge clk);
        rst = 1'b0;

        issue(1, P_NOP, 3'd0, '0, "R4 nop");
        issue(1, P_X,   3'd4, 15'h1234, "R4 unmapped code");
        issue(1, P_DES, 3'd6, 15'h7FFF, "R3 deselect");
        issue(1, P_ACT, 3'd2, 15'h5A5A, "R5 activate bank2");
        issue(1, P_ACT, 3'd5, 15'h7FFF, "R5 activate bank5 full row");
        issue(1, P_ACT, 3'd2, 15'h0001, "R10 reactivate open bank");
        issue(1, P_RD,  3'd2, rw_addr(10'h3FF, 0, 1), "R8 otf reset A12=1 R6 read");
        issue(1, P_RD,  3'd2, rw_addr(10'h001, 0, 0), "R8 otf A12=0");
        issue(1, P_RD,  3'd3, rw_addr(10'h055, 0, 1), "R10 read closed bank");
        issue(0, P_ACT, 3'd3, 15'h0100, "R2 stalled activate");
        issue(1, P_RD,  3'd3, rw_addr(10'h0AA, 0, 1), "R2 bank3 still closed");
        issue(1, P_REF, 3'd1, 15'h0400, "R4 refresh R11");
        issue(1, P_WR,  3'd5, rw_addr(10'h155, 1, 1), "R6 write autopre");
        issue(1, P_WR,  3'd5, rw_addr(10'h000, 0, 1), "R10 write after autopre");
        issue(1, P_MRS, 3'd1, 15'h1232, "R9 load MR1 no burst change");
        issue(1, P_RD,  3'd2, rw_addr(10'h010, 0, 0), "R9 mode still otf");
        issue(1, P_MRS, 3'd0, 15'h0002, "R9 load MR0 chop4");
        issue(1, P_RD,  3'd2, rw_addr(10'h020, 0, 1), "R8 fixed chop4");
        issue(1, P_MRS, 3'd0, 15'h0000, "R9 load MR0 fixed8");
        issue(1, P_WR,  3'd2, rw_addr(10'h030, 0, 0), "R8 fixed burst8");
        issue(1, P_MRS, 3'd0, 15'h0003, "R9 load MR0 code11");
        issue(1, P_RD,  3'd2, rw_addr(10'h040, 0, 0), "R8 code11 uses A12");
        issue(1, P_ACT, 3'd0, 15'h0400, "R5 activate bank0 A10 set");
        issue(1, P_ACT, 3'd7, 15'h2000, "R5 activate bank7");
        issue(1, P_PRE, 3'd0, 15'h0000, "R7 precharge single");
        issue(1, P_PRE, 3'd0, 15'h0400, "R7 precharge all");
        issue(1, P_RD,  3'd7, rw_addr(10'h001, 0, 1), "R10 read after pre-all");
        issue(0, P_PRE, 3'd0, 15'h0400, "R2 stalled precharge");
        issue(1, P_NOP, 3'd0, '0, "R4 final nop");
        repeat (3) @(posedge clk);
        #2;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule